// File: doc/BRIEF.md
# Floating-Point Sticky Exception Flag Register

This block keeps the floating-point status flags of a processor status word. Each time an arithmetic operation finishes, the datapath presents a vector of exception conditions together with a valid strobe. The block folds those conditions into five sticky flags (invalid, overflow, divide-by-zero, underflow, inexact) and into a summary flag that tells whether the latest operation raised anything at all.

Software can also rewrite the flags through an update-flags operand of 16 bits. The upper byte is a write mask and the lower byte carries the new values, so a single write can set, clear or keep each flag on its own. The current flag values are always visible on the output.

Top module: `fpu_flag_reg`

## Requirements
- R1: An active-low asynchronous reset (rst_ni) clears every flag to 0. The flag output encoding is flags_o[5]=summary, [4]=invalid, [3]=overflow, [2]=divide-by-zero, [1]=underflow, [0]=inexact.
- R2: With op_valid_i high, condition bit op_cond_i[4] (invalid) sets the invalid flag, op_cond_i[3] (overflow) sets the overflow flag and op_cond_i[2] (divide-by-zero) sets the divide-by-zero flag on the next clock edge.
- R3: op_cond_i[1] (underflow) or op_cond_i[5] (output denormal) sets the underflow flag; op_cond_i[0] (inexact) or op_cond_i[5] sets the inexact flag.
- R4: On an operation the summary flag becomes 1 if any of op_cond_i[5:0] is set and 0 if none is set.
- R5: The invalid, overflow, divide-by-zero, underflow and inexact flags are sticky: an operation never clears them.
- R6: op_cond_i[6] (input denormal) is ignored: alone it sets no flag and counts as no exception for the summary flag.
- R7: With upd_valid_i high, each flag whose mask bit is 1 loads its value bit; the mask/value bits of upd_operand_i are summary 15/7, invalid 14/6, overflow 13/5, divide-by-zero 12/4, underflow 11/3, inexact 10/2.
- R8: A flag whose mask bit is 0 keeps its value during an update-flags write; bits 9:8 and 1:0 of the operand have no effect.
- R9: When upd_valid_i and op_valid_i are high in the same cycle, the update-flags write applies and the operation's conditions are dropped.
- R10: With neither strobe high the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation reports its exception conditions |
| op_cond_i | input | 7 | Exception conditions of the operation |
| upd_valid_i | input | 1 | Update-flags write strobe |
| upd_operand_i | input | 16 | Mask byte (15:8) and value byte (7:0) |
| flags_o | output | 6 | Current flag values |

## Verification
The bench targets the output-denormal condition, which a design that wired it to only one flag would leave underflow or inexact clear, and a clean operation after a faulty one, where a design that cleared sticky flags would lose history or one that kept the summary flag would report a stale exception. It drives input-denormal alone, where a design counting it would raise the summary flag, and partial-mask writes, where a design writing all bits would corrupt unmasked flags. Simultaneous write and operation strobes expose a design that merges the operation's bits into a software write.

// File: rtl/fflag_pkg.sv
package fflag_pkg;
  localparam int unsigned COND_W = 7;
  localparam int unsigned NFLAG  = 6;
  localparam int unsigned OPND_W = 16;
  localparam int unsigned VAL_LSB  = 2;
  localparam int unsigned MASK_LSB = 10;

  // condition bit positions
  localparam int unsigned C_INX  = 0;
  localparam int unsigned C_UNF  = 1;
  localparam int unsigned C_DZ   = 2;
  localparam int unsigned C_OVF  = 3;
  localparam int unsigned C_INV  = 4;
  localparam int unsigned C_ODEN = 5;
  localparam int unsigned C_IDEN = 6;

  // flag bit positions
  localparam int unsigned F_FX  = 0;
  localparam int unsigned F_FU  = 1;
  localparam int unsigned F_FZ  = 2;
  localparam int unsigned F_FV  = 3;
  localparam int unsigned F_FI  = 4;
  localparam int unsigned F_SUM = 5;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/fflag_cond_map.sv
module fflag_cond_map
  import fflag_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  output flag_vec_t         set_o
);
  localparam logic [COND_W-1:0] LIVE_MASK = ~(COND_W'(1) << C_IDEN);

  logic [COND_W-1:0] live;
  assign live = cond_i & LIVE_MASK;

  always_comb begin
    set_o        = '0;
    set_o[F_FI]  = live[C_INV];
    set_o[F_FV]  = live[C_OVF];
    set_o[F_FZ]  = live[C_DZ];
    set_o[F_FU]  = live[C_UNF] | live[C_ODEN];
    set_o[F_FX]  = live[C_INX] | live[C_ODEN];
    set_o[F_SUM] = |live;
  end
endmodule

// File: rtl/fflag_sw_unpack.sv
module fflag_sw_unpack
  import fflag_pkg::*;
(
  input  logic [OPND_W-1:0] operand_i,
  output flag_vec_t         mask_o,
  output flag_vec_t         val_o
);
  logic [OPND_W-1:0] unused_bits;
  assign unused_bits = operand_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_pair
    assign mask_o[i] = operand_i[MASK_LSB+i];
    assign val_o[i]  = operand_i[VAL_LSB+i];
  end
endmodule

// File: rtl/fflag_cell.sv
module fflag_cell #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_we_i,
  input  logic sw_val_i,
  input  logic hw_we_i,
  input  logic hw_set_i,
  output logic q_o
);
  logic d;

  if (STICKY) begin : g_sticky
    always_comb begin
      d = q_o;
      if (sw_we_i)      d = sw_val_i;
      else if (hw_we_i) d = q_o | hw_set_i;
    end
  end else begin : g_plain
    always_comb begin
      d = q_o;
      if (sw_we_i)      d = sw_val_i;
      else if (hw_we_i) d = hw_set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/fpu_flag_reg.sv
module fpu_flag_reg
  import fflag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [COND_W-1:0] op_cond_i,
  input  logic              upd_valid_i,
  input  logic [OPND_W-1:0] upd_operand_i,
  output logic [NFLAG-1:0]  flags_o
);
  flag_vec_t hw_set, sw_mask, sw_val;
  logic      hw_we;

  fflag_cond_map u_map (
    .cond_i (op_cond_i),
    .set_o  (hw_set)
  );

  fflag_sw_unpack u_unpack (
    .operand_i (upd_operand_i),
    .mask_o    (sw_mask),
    .val_o     (sw_val)
  );

  // software write wins; drop the operation entirely
  assign hw_we = op_valid_i & ~upd_valid_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    fflag_cell #(.STICKY(i != F_SUM)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sw_we_i  (upd_valid_i & sw_mask[i]),
      .sw_val_i (sw_val[i]),
      .hw_we_i  (hw_we),
      .hw_set_i (hw_set[i]),
      .q_o      (flags_o[i])
    );
  end
endmodule

// File: rtl/fflag_chk.sv
module fflag_chk
  import fflag_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [COND_W-1:0] op_cond_i,
  input logic              upd_valid_i,
  input logic [OPND_W-1:0] upd_operand_i,
  input logic [NFLAG-1:0]  flags_o
);
  logic [NFLAG-1:0] m, v;
  assign m = upd_operand_i[MASK_LSB +: NFLAG];
  assign v = upd_operand_i[VAL_LSB +: NFLAG];

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> flags_o == '0);

  assert_inv_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !upd_valid_i && op_cond_i[C_INV] |=> flags_o[F_FI]);

  assert_oden_fold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !upd_valid_i && op_cond_i[C_ODEN] |=> flags_o[F_FU] && flags_o[F_FX]);

  assert_summary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !upd_valid_i |=> flags_o[F_SUM] == $past(|op_cond_i[C_ODEN:0]));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !upd_valid_i |=>
      (flags_o[F_FI:0] & $past(flags_o[F_FI:0])) == $past(flags_o[F_FI:0]));

  assert_iden_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !upd_valid_i && op_cond_i[C_ODEN:0] == '0 |=>
      !flags_o[F_SUM] && flags_o[F_FI:0] == $past(flags_o[F_FI:0]));

  assert_masked_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (flags_o & $past(m)) == ($past(v) & $past(m)));

  // also covers R9: operation ignored under a write
  assert_unmasked_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (flags_o & ~$past(m)) == ($past(flags_o) & ~$past(m)));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i && !upd_valid_i |=> $stable(flags_o));
endmodule

bind fpu_flag_reg fflag_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .op_valid_i    (op_valid_i),
  .op_cond_i     (op_cond_i),
  .upd_valid_i   (upd_valid_i),
  .upd_operand_i (upd_operand_i),
  .flags_o       (flags_o)
);

// File: tb/tb_fpu_flag_reg.sv
module tb_fpu_flag_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [6:0]  op_cond_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [15:0] upd_operand_i = '0;
  logic [5:0]  flags_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [5:0] exp_f = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpu_flag_reg dut (.*);

  // flag order: 5 sum, 4 inv, 3 ovf, 2 dz, 1 unf, 0 inx
  function automatic logic [5:0] model(logic [5:0] cur, logic ov, logic [6:0] c,
                                       logic uv, logic [15:0] opd);
    logic [5:0] n, s;
    n = cur;
    if (uv) begin
      for (int i = 0; i < 6; i++)
        if (opd[10+i]) n[i] = opd[2+i];
    end else if (ov) begin
      s[4] = c[4]; s[3] = c[3]; s[2] = c[2];
      s[1] = c[1] | c[5]; s[0] = c[0] | c[5];
      s[5] = |c[5:0];
      n[4:0] = cur[4:0] | s[4:0];
      n[5] = s[5];
    end
    return n;
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: flags=%b expected=%b", req, act, exp);
    end
  endtask

  // called at a negedge: drive, then check at the next negedge
  task automatic step(logic ov, logic [6:0] c, logic uv, logic [15:0] opd, string req);
    op_valid_i = ov; op_cond_i = c; upd_valid_i = uv; upd_operand_i = opd;
    exp_f = model(exp_f, ov, c, uv, opd);
    @(negedge clk_i);
    check(req, flags_o, exp_f);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    check("R1", flags_o, 6'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", flags_o, 6'b0);

    step(1, 7'b0010000, 0, '0, "R2");          // invalid -> FI, sum
    step(1, 7'b0001000, 0, '0, "R2");          // overflow -> FV
    step(1, 7'b0000100, 0, '0, "R2");          // div0 -> FZ
    step(0, '0, 1, 16'hFC00, "R7");            // clear all
    check("R7", flags_o, 6'b0);
    step(1, 7'b0100000, 0, '0, "R3");          // out denorm -> FU, FX
    check("R3", flags_o, 6'b100011);
    step(1, 7'b0000000, 0, '0, "R4");          // clean op: sum drops
    check("R5", flags_o, 6'b000011);
    step(1, 7'b1000000, 0, '0, "R6");          // in denorm alone
    check("R6", flags_o, 6'b000011);
    step(0, '0, 1, 16'h0404 | 16'h0300, "R8"); // FX only, junk low/mid bits
    step(0, '0, 1, 16'h0880, "R8");            // mask FU clear, val sum ignored
    check("R8", flags_o, 6'b000001);
    step(1, 7'b0011111, 1, 16'h2020, "R9");    // write wins
    check("R9", flags_o, 6'b001001);
    step(0, '0, 0, 16'hFFFF, "R10");

    for (int k = 0; k < 3000; k++) begin
      logic ov, uv;
      logic [6:0] c;
      logic [15:0] opd;
      string req;
      ov = ($urandom % 3) != 0;
      uv = ($urandom % 4) == 0;
      c = 7'($urandom);
      if ($urandom % 3 == 0) c = 7'(c & 7'b1000000);
      opd = 16'($urandom);
      if ($urandom % 2 == 0) opd = 16'h0000 | opd[7:0]; // value-only, no effect
      if (uv) req = ov ? "R9" : ((opd[15:10] == 0) ? "R8" : "R7");
      else if (ov) req = (c[5:0] == 0) ? "R4" : "R5";
      else req = "R10";
      step(ov, c, uv, opd, req);
    end

    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    exp_f = '0;
    check("R1", flags_o, 6'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule